// File: doc/BRIEF.md
# Scratchpad Staging and Copy Engine with CRC-16

This block is the memory command layer of a small nonvolatile memory that is reached over a byte-serial slave link. Every change to main memory goes through an eight-byte staging buffer. The master loads the buffer with a write command. It reads the buffer back, together with a CRC-16, to confirm that the data arrived intact. It then commits the data with a copy command. The copy only runs if the master echoes the stored target address and the ending-offset/status byte. Main memory can also be read directly, starting at any address.

The master marks the start of each transaction with a one-cycle `busReset` pulse and then sends a one-byte command. Each byte the master sends arrives on `rxByte` with a one-cycle `rxValid` strobe. The master asks for a byte from the engine with a one-cycle `txReq`. Main memory is a register array covering addresses 00h to 8Fh: 18 rows of 8 bytes. A successful copy occupies the engine for a fixed, parameterised number of cycles, which models the programming time of the storage.

Top module: `scratchpad_engine`

## Requirements
- R1: After `rstN` is released:
  - `txValid` is low.
  - The target address and the status byte are 0.
  - The buffer holds 00h.
  - Every memory byte reads FFh.
  - The engine accepts a command without a prior `busReset`.
- R2: Write command 0Fh is followed by the target address (low byte, then high byte) and then data bytes.
  - The first data byte lands at buffer offset TA[2:0], and each later byte lands one offset higher.
  - The status byte reads bit 7 = authorization flag, bits 6:3 = 0, and bits 2:0 = the offset of the last byte written.
- R3: The CRC-16 uses polynomial x^16+x^15+x^2+1, a zero initial value, and LSB-first shifting. After a write, it covers the command, TA low, TA high and the stored data bytes.
  - It is sent inverted, low byte first, and only once a write has stored offset 7.
  - Before that, and after the two CRC bytes, every requested byte is FFh.
- R4: Once offset 7 has been written, further data bytes in the same write are ignored. They change neither the buffer nor the CRC.
- R5: Read command AAh returns, in this order:
  - TA low, TA high and the status byte;
  - the buffer bytes from offset TA[2:0] up to offset 7;
  - the inverted CRC-16 over AAh, the three header bytes and the data bytes;
  - then FFh for every further request.
- R6: Copy command 55h is followed by three authorization bytes. When all three equal TA low, TA high and the status byte:
  - the authorization flag is set;
  - for PROG_CYCLES requests the engine replies 00h, and after that it replies AAh;
  - at the end of the delay, buffer offsets TA[2:0] through E are written to the memory row addressed by TA[15:3].
- R7: A copy whose authorization bytes differ from the stored values changes no memory, leaves the flag clear and answers FFh.
- R8: Any byte stored into the buffer clears the authorization flag.
- R9: Read-memory command F0h takes a two-byte start address and returns successive memory bytes. Requests past 8Fh return FFh. The command leaves the target address, the status byte and the buffer unchanged.
- R10: Bytes received during the programming delay are ignored. `busReset` still returns the engine to command state, and a copy whose final delay cycle coincides with `busReset` still commits.
- R11: `txValid` is high exactly in the cycle after a `txReq`, with the reply on `txData`. An unknown command makes the engine answer FFh until the next `busReset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Transaction start pulse; returns the engine to command state |
| rxValid | input | 1 | Strobe: a byte from the master is present on rxByte |
| rxByte | input | 8 | Byte from the master |
| txReq | input | 1 | Master requests one byte from the engine |
| txData | output | 8 | Reply byte, valid while txValid is high |
| txValid | output | 1 | High one cycle after txReq |

## Verification
The memory commit at the end of the programming delay and a `busReset` can fall in the same cycle. The bench counts its reply requests from the last authorization byte, so that the reset pulse lands exactly on the final busy edge. It then judges the result through a memory read of the committed row, a read past 8Fh, and the status byte, which must still show the flag. A second scenario issues a reset early in the delay and feeds a complete write command while the engine is busy. The later buffer read must show none of those bytes.

// File: rtl/scratchpad_pkg.sv
package scratchpad_pkg;

  localparam logic [7:0] CMD_WRITE_SP = 8'h0F;
  localparam logic [7:0] CMD_READ_SP  = 8'hAA;
  localparam logic [7:0] CMD_COPY_SP  = 8'h55;
  localparam logic [7:0] CMD_READ_MEM = 8'hF0;
  localparam logic [7:0] REPLY_DONE   = 8'hAA;
  localparam logic [7:0] REPLY_BUSY   = 8'h00;
  localparam logic [7:0] REPLY_IDLE   = 8'hFF;

  typedef enum logic [3:0] {
    TX_ONES, TX_TALO, TX_TAHI, TX_ES, TX_SP,
    TX_CRCLO, TX_CRCHI, TX_MEM, TX_COPY
  } txSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   crcClear;
    logic   crcFeedRx;
    logic   crcFeedTx;
    logic   taLoLoad;
    logic   taHiLoad;
    logic   offLoad;
    logic   offInc;
    logic   spWrite;
    logic   startProg;
    logic   ptrLoLoad;
    logic   ptrHiLoad;
    logic   ptrInc;
    logic   txLoad;
    txSel_e txSel;
  } dpCtl_t;

  // reflected polynomial 0xA001, one byte shifted in LSB first
  function automatic logic [15:0] crc16Step(logic [15:0] crcIn, logic [7:0] dataIn);
    logic [15:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ dataIn[i]) c = (c >> 1) ^ 16'hA001;
      else                  c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/scratchpad_crc16.sv
module scratchpad_crc16 (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic        feed,
  input  logic [7:0]  dataIn,
  output logic [15:0] crc
);
  import scratchpad_pkg::*;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      crc <= '0;
    else if (clear) crc <= feed ? crc16Step(16'h0000, dataIn) : 16'h0000;
    else if (feed)  crc <= crc16Step(crc, dataIn);
  end
endmodule

// File: rtl/scratchpad_datapath.sv
module scratchpad_datapath #(
  parameter int MEM_BYTES   = 144,
  parameter int SP_BYTES    = 8,
  parameter int ADDR_W      = 16,
  parameter int PROG_CYCLES = 20
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [7:0]                  rxByte,
  input  scratchpad_pkg::dpCtl_t      ctl,
  output logic [7:0]                  taLo,
  output logic [7:0]                  taHi,
  output logic [7:0]                  esByte,
  output logic [$clog2(SP_BYTES)-1:0] offset,
  output logic                        progBusy,
  output logic [7:0]                  txData,
  output logic                        txValid
);
  import scratchpad_pkg::*;

  localparam int OFF_W = $clog2(SP_BYTES);
  localparam int ROW_W = ADDR_W - OFF_W;
  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int PCW = $clog2(PROG_CYCLES + 1);

  logic [ADDR_W-1:0] ta;
  logic [ADDR_W-1:0] memPtr;
  logic [7:0]        sp [SP_BYTES];
  logic [7:0]        mem [MEM_BYTES];
  logic [OFF_W-1:0]  endOff;
  logic              authFlag;
  logic [PCW-1:0]    progCnt;
  logic              commit;
  logic [15:0]       crc;
  logic [7:0]        txNext;
  logic [7:0]        memByte;

  assign taLo     = ta[7:0];
  assign taHi     = ta[15:8];
  assign esByte   = {authFlag, {(7-OFF_W){1'b0}}, endOff};
  assign progBusy = (progCnt != '0);
  assign commit   = (progCnt == PCW'(1));

  scratchpad_crc16 u_crc (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (ctl.crcClear),
    .feed   (ctl.crcFeedRx | ctl.crcFeedTx),
    .dataIn (ctl.crcFeedRx ? rxByte : txNext),
    .crc    (crc)
  );

  // target address and read pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ta     <= '0;
      memPtr <= '0;
    end else begin
      if (ctl.taLoLoad)  ta[7:0]      <= rxByte;
      if (ctl.taHiLoad)  ta[15:8]     <= rxByte;
      if (ctl.ptrLoLoad) memPtr[7:0]  <= rxByte;
      if (ctl.ptrHiLoad) memPtr[15:8] <= rxByte;
      if (ctl.ptrInc)    memPtr       <= memPtr + 1'b1;
    end
  end

  // staging buffer, ending offset and authorization flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SP_BYTES; i++) sp[i] <= '0;
      offset   <= '0;
      endOff   <= '0;
      authFlag <= 1'b0;
    end else begin
      if (ctl.offLoad)     offset <= ta[OFF_W-1:0];
      else if (ctl.offInc) offset <= offset + 1'b1;
      if (ctl.spWrite) begin
        sp[offset] <= rxByte;
        endOff     <= offset;
        authFlag   <= 1'b0;
      end else if (ctl.startProg) begin
        authFlag <= 1'b1;
      end
    end
  end

  // programming delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              progCnt <= '0;
    else if (ctl.startProg) progCnt <= PCW'(PROG_CYCLES);
    else if (progBusy)      progCnt <= progCnt - 1'b1;
  end

  // main memory, written only on the last programming cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < MEM_BYTES; a++) mem[a] <= 8'hFF;
    end else if (commit) begin
      for (int a = 0; a < MEM_BYTES; a++) begin
        if (ta[ADDR_W-1:OFF_W] == ROW_W'(a / SP_BYTES) &&
            OFF_W'(a % SP_BYTES) >= ta[OFF_W-1:0] &&
            OFF_W'(a % SP_BYTES) <= endOff)
          mem[a] <= sp[a % SP_BYTES];
      end
    end
  end

  assign memByte = (memPtr < ADDR_W'(MEM_BYTES)) ? mem[memPtr[MEM_AW-1:0]] : REPLY_IDLE;

  always_comb begin
    case (ctl.txSel)
      TX_TALO:  txNext = ta[7:0];
      TX_TAHI:  txNext = ta[15:8];
      TX_ES:    txNext = esByte;
      TX_SP:    txNext = sp[offset];
      TX_CRCLO: txNext = ~crc[7:0];
      TX_CRCHI: txNext = ~crc[15:8];
      TX_MEM:   txNext = memByte;
      TX_COPY:  txNext = progBusy ? REPLY_BUSY : REPLY_DONE;
      default:  txNext = REPLY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData  <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= ctl.txLoad;
      if (ctl.txLoad) txData <= txNext;
    end
  end
endmodule

// File: rtl/scratchpad_ctrl.sv
module scratchpad_ctrl #(
  parameter int SP_BYTES = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busReset,
  input  logic                        rxValid,
  input  logic [7:0]                  rxByte,
  input  logic                        txReq,
  input  logic [7:0]                  taLo,
  input  logic [7:0]                  taHi,
  input  logic [7:0]                  esByte,
  input  logic [$clog2(SP_BYTES)-1:0] offset,
  input  logic                        progBusy,
  output scratchpad_pkg::dpCtl_t      ctl
);
  import scratchpad_pkg::*;

  localparam int OFF_W = $clog2(SP_BYTES);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(SP_BYTES - 1);

  typedef enum logic [3:0] {
    S_CMD, S_WS_A1, S_WS_A2, S_WS_DATA, S_RS_HDR, S_RS_DATA, S_CRC,
    S_CP_A1, S_CP_A2, S_CP_ES, S_CP_RESP, S_RM_A1, S_RM_A2, S_RM_TX, S_TAIL
  } state_e;

  state_e     state, stateNext;
  logic [1:0] phase, phaseNext;
  logic       authBad, authBadNext;
  logic       rxGo;

  assign rxGo = rxValid && !progBusy;

  always_comb begin
    ctl         = '0;
    ctl.txSel   = TX_ONES;
    ctl.txLoad  = txReq;
    stateNext   = state;
    phaseNext   = phase;
    authBadNext = authBad;
    if (busReset) begin
      stateNext = S_CMD;
      phaseNext = '0;
    end else begin
      case (state)
        S_CMD: if (rxGo) begin
          phaseNext = '0;
          case (rxByte)
            CMD_WRITE_SP: begin
              ctl.crcClear  = 1'b1;
              ctl.crcFeedRx = 1'b1;
              stateNext     = S_WS_A1;
            end
            CMD_READ_SP: begin
              ctl.crcClear  = 1'b1;
              ctl.crcFeedRx = 1'b1;
              ctl.offLoad   = 1'b1;
              stateNext     = S_RS_HDR;
            end
            CMD_COPY_SP: begin
              authBadNext = 1'b0;
              stateNext   = S_CP_A1;
            end
            CMD_READ_MEM: stateNext = S_RM_A1;
            default:      stateNext = S_TAIL;
          endcase
        end
        S_WS_A1: if (rxGo) begin
          ctl.taLoLoad  = 1'b1;
          ctl.crcFeedRx = 1'b1;
          stateNext     = S_WS_A2;
        end
        S_WS_A2: if (rxGo) begin
          ctl.taHiLoad  = 1'b1;
          ctl.crcFeedRx = 1'b1;
          ctl.offLoad   = 1'b1;
          stateNext     = S_WS_DATA;
        end
        S_WS_DATA: if (rxGo) begin
          ctl.spWrite   = 1'b1;
          ctl.crcFeedRx = 1'b1;
          if (offset == LAST_OFF) begin
            stateNext = S_CRC;
            phaseNext = '0;
          end else begin
            ctl.offInc = 1'b1;
          end
        end
        S_RS_HDR: if (txReq) begin
          ctl.crcFeedTx = 1'b1;
          case (phase)
            2'd0:    ctl.txSel = TX_TALO;
            2'd1:    ctl.txSel = TX_TAHI;
            default: ctl.txSel = TX_ES;
          endcase
          if (phase == 2'd2) begin
            stateNext = S_RS_DATA;
            phaseNext = '0;
          end else begin
            phaseNext = phase + 1'b1;
          end
        end
        S_RS_DATA: if (txReq) begin
          ctl.txSel     = TX_SP;
          ctl.crcFeedTx = 1'b1;
          if (offset == LAST_OFF) begin
            stateNext = S_CRC;
            phaseNext = '0;
          end else begin
            ctl.offInc = 1'b1;
          end
        end
        S_CRC: if (txReq) begin
          if (phase == 2'd0) begin
            ctl.txSel = TX_CRCLO;
            phaseNext = 2'd1;
          end else begin
            ctl.txSel = TX_CRCHI;
            stateNext = S_TAIL;
          end
        end
        S_CP_A1: if (rxGo) begin
          authBadNext = authBad | (rxByte != taLo);
          stateNext   = S_CP_A2;
        end
        S_CP_A2: if (rxGo) begin
          authBadNext = authBad | (rxByte != taHi);
          stateNext   = S_CP_ES;
        end
        S_CP_ES: if (rxGo) begin
          if (!authBad && rxByte == esByte) begin
            ctl.startProg = 1'b1;
            stateNext     = S_CP_RESP;
          end else begin
            stateNext = S_TAIL;
          end
        end
        S_CP_RESP: ctl.txSel = TX_COPY;
        S_RM_A1: if (rxGo) begin
          ctl.ptrLoLoad = 1'b1;
          stateNext     = S_RM_A2;
        end
        S_RM_A2: if (rxGo) begin
          ctl.ptrHiLoad = 1'b1;
          stateNext     = S_RM_TX;
        end
        S_RM_TX: if (txReq) begin
          ctl.txSel  = TX_MEM;
          ctl.ptrInc = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_CMD;
      phase   <= '0;
      authBad <= 1'b0;
    end else begin
      state   <= stateNext;
      phase   <= phaseNext;
      authBad <= authBadNext;
    end
  end
endmodule

// File: rtl/scratchpad_engine.sv
module scratchpad_engine #(
  parameter int MEM_BYTES   = 144,
  parameter int SP_BYTES    = 8,
  parameter int ADDR_W      = 16,
  parameter int PROG_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReq,
  output logic [7:0] txData,
  output logic       txValid
);
  import scratchpad_pkg::*;

  localparam int OFF_W = $clog2(SP_BYTES);

  dpCtl_t           ctl;
  logic [7:0]       taLo;
  logic [7:0]       taHi;
  logic [7:0]       esByte;
  logic [OFF_W-1:0] offset;
  logic             progBusy;

  scratchpad_ctrl #(.SP_BYTES(SP_BYTES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReset (busReset),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .txReq    (txReq),
    .taLo     (taLo),
    .taHi     (taHi),
    .esByte   (esByte),
    .offset   (offset),
    .progBusy (progBusy),
    .ctl      (ctl)
  );

  scratchpad_datapath #(
    .MEM_BYTES   (MEM_BYTES),
    .SP_BYTES    (SP_BYTES),
    .ADDR_W      (ADDR_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxByte   (rxByte),
    .ctl      (ctl),
    .taLo     (taLo),
    .taHi     (taHi),
    .esByte   (esByte),
    .offset   (offset),
    .progBusy (progBusy),
    .txData   (txData),
    .txValid  (txValid)
  );
endmodule

// File: rtl/scratchpad_engine_chk.sv
module scratchpad_engine_chk #(
  parameter int PROG_CYCLES = 20
) (
  input logic clk,
  input logic rstN,
  input logic rxValid,
  input logic txReq,
  input logic txValid,
  input logic progBusy,
  input logic esAuth
);
  int busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         busyRun <= 0;
    else if (progBusy) busyRun <= busyRun + 1;
    else               busyRun <= 0;
  end

  AST_TX_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> txValid) else $error("reply missing"); // R11

  AST_NO_SPURIOUS_TX: assert property (@(posedge clk) disable iff (!rstN)
    !txReq |=> !txValid) else $error("unrequested reply"); // R11

  AST_PROG_FROM_RX: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> $past(rxValid)) else $error("delay started without a byte"); // R6

  AST_AUTH_ON_PROG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progBusy) |-> esAuth) else $error("flag not set at copy start"); // R6

  AST_AUTH_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |=> esAuth) else $error("flag cleared during delay"); // R10

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= PROG_CYCLES) else $error("delay too long"); // R6
endmodule

bind scratchpad_engine scratchpad_engine_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rxValid  (rxValid),
  .txReq    (txReq),
  .txValid  (txValid),
  .progBusy (progBusy),
  .esAuth   (esByte[7])
);

// File: tb/scratchpad_engine_test.sv
module scratchpad_engine_test;
  localparam int PROG = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReset = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       txReq = 1'b0;
  logic [7:0] txData;
  logic       txValid;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [7:0] spM [8];

  always #10 clk = ~clk;

  scratchpad_engine #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxByte(rxByte), .txReq(txReq), .txData(txData), .txValid(txValid)
  );

  function automatic logic [15:0] crcStep(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // all stimulus tasks start and end just after a falling edge
  task automatic sendB(logic [7:0] b);
    rxValid = 1'b1; rxByte = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic expectB(string req, logic [7:0] exp);
    txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
    check("R11 txValid", {7'b0, txValid}, 8'h01);
    check(req, txData, exp);
  endtask

  task automatic busRst();
    busReset = 1'b1;
    @(negedge clk);
    busReset = 1'b0;
  endtask

  task automatic writeSp(logic [15:0] ta, int n, logic [7:0] base, output logic [15:0] c);
    int off;
    busRst();
    sendB(8'h0F); c = crcStep(16'h0, 8'h0F);
    sendB(ta[7:0]); c = crcStep(c, ta[7:0]);
    sendB(ta[15:8]); c = crcStep(c, ta[15:8]);
    for (int k = 0; k < n; k++) begin
      off = int'(ta[2:0]) + k;
      sendB(base + 8'(k));
      if (off <= 7) begin
        spM[off] = base + 8'(k);
        c = crcStep(c, base + 8'(k));
      end
    end
  endtask

  task automatic readSpCheck(string req, logic [15:0] ta, logic [7:0] es);
    logic [15:0] c;
    busRst();
    sendB(8'hAA); c = crcStep(16'h0, 8'hAA);
    expectB(req, ta[7:0]); c = crcStep(c, ta[7:0]);
    expectB(req, ta[15:8]); c = crcStep(c, ta[15:8]);
    expectB(req, es); c = crcStep(c, es);
    for (int i = int'(ta[2:0]); i < 8; i++) begin
      expectB(req, spM[i]);
      c = crcStep(c, spM[i]);
    end
    expectB({req, " crc"}, ~c[7:0]);
    expectB({req, " crc"}, ~c[15:8]);
    expectB({req, " tail"}, 8'hFF);
  endtask

  task automatic startMemRead(logic [15:0] addr);
    busRst();
    sendB(8'hF0);
    sendB(addr[7:0]);
    sendB(addr[15:8]);
  endtask

  task automatic testReset();
    check("R1 txValid idle", {7'b0, txValid}, 8'h00);
    for (int i = 0; i < 8; i++) spM[i] = 8'h00;
    startMemRead(16'h0000);
    for (int i = 0; i < 4; i++) expectB("R1 memory erased", 8'hFF);
    readSpCheck("R1", 16'h0000, 8'h00);
  endtask

  task automatic testFullWrite();
    logic [15:0] c;
    writeSp(16'h0020, 8, 8'h10, c);
    expectB("R3 crc low", ~c[7:0]);
    expectB("R3 crc high", ~c[15:8]);
    expectB("R3 ones after crc", 8'hFF);
    readSpCheck("R5", 16'h0020, 8'h07);
  endtask

  task automatic testPartialWrite();
    logic [15:0] c;
    writeSp(16'h0043, 2, 8'hA0, c);
    expectB("R3 no crc before offset 7", 8'hFF);
    readSpCheck("R2", 16'h0043, 8'h04);
  endtask

  task automatic testOverflow();
    logic [15:0] c;
    writeSp(16'h0006, 3, 8'h61, c);
    expectB("R4 crc low", ~c[7:0]);
    expectB("R4 crc high", ~c[15:8]);
    readSpCheck("R4", 16'h0006, 8'h07);
  endtask

  task automatic testCopyBad();
    busRst();
    sendB(8'h55); sendB(8'h06); sendB(8'h00); sendB(8'h00);
    expectB("R7 reply", 8'hFF);
    repeat (PROG + 2) @(negedge clk);
    startMemRead(16'h0006);
    expectB("R7 memory", 8'hFF);
    expectB("R7 memory", 8'hFF);
    readSpCheck("R7", 16'h0006, 8'h07);
  endtask

  task automatic testCopyGood();
    logic [15:0] c;
    writeSp(16'h0008, 8, 8'h80, c);
    busRst();
    sendB(8'h55); sendB(8'h08); sendB(8'h00); sendB(8'h07);
    repeat (PROG) expectB("R6 busy", 8'h00);
    expectB("R6 done", 8'hAA);
    expectB("R6 done", 8'hAA);
    startMemRead(16'h0007);
    expectB("R6 neighbour", 8'hFF);
    for (int i = 0; i < 8; i++) expectB("R6 copied", 8'h80 + 8'(i));
    readSpCheck("R9", 16'h0008, 8'h87);
  endtask

  task automatic testClearAuth();
    logic [15:0] c;
    writeSp(16'h0008, 1, 8'h99, c);
    readSpCheck("R8", 16'h0008, 8'h00);
  endtask

  task automatic testBusyIgnore();
    busRst();
    sendB(8'h55); sendB(8'h08); sendB(8'h00); sendB(8'h00);
    busRst();
    sendB(8'h0F); sendB(8'h08); sendB(8'h00); sendB(8'h55);
    repeat (PROG) @(negedge clk);
    readSpCheck("R10", 16'h0008, 8'h80);
    startMemRead(16'h0008);
    expectB("R6 range start", 8'h99);
    expectB("R6 range end", 8'h81);
  endtask

  task automatic testCoincide();
    logic [15:0] c;
    writeSp(16'h0088, 8, 8'hC0, c);
    busRst();
    sendB(8'h55); sendB(8'h88); sendB(8'h00); sendB(8'h07);
    repeat (PROG - 1) expectB("R6 busy", 8'h00);
    busRst();
    startMemRead(16'h008C);
    for (int i = 4; i < 8; i++) expectB("R10 commit", 8'hC0 + 8'(i));
    expectB("R9 past end", 8'hFF);
    expectB("R9 past end", 8'hFF);
    readSpCheck("R10", 16'h0088, 8'h87);
  endtask

  task automatic testUnknown();
    busRst();
    sendB(8'h33);
    expectB("R11 unknown", 8'hFF);
    expectB("R11 unknown", 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullWrite();
    testPartialWrite();
    testOverflow();
    testCopyBad();
    testCopyGood();
    testClearAuth();
    testBusyIgnore();
    testCoincide();
    testUnknown();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule